// File: doc/BRIEF.md
# Calendar Counter with Masked Alarm

This block keeps wall-clock time and date in seven separate fields: second, minute, hour, day of month, day of week, month and a year offset. A one-second strobe advances the time, with carries that follow the calendar, including month lengths and leap years. The year is a 7-bit offset covering 128 years, and offset 0 is a leap year.

The alarm is a second set of the same fields, compared with the time once per second. Any field can be left out of that comparison through a per-field mask.

Two event sources, an alarm and a one-second tick, each have a status bit and an enable bit. They drive one active-low, level-sensitive interrupt line. A one-shot mode disarms the alarm in hardware once it has fired. The surrounding logic writes time, alarm, mask, enables and status clears through simple write strobes with data.

Top module: `cal_alarm_rtc`

## Requirements
- R1: A `time_wr` pulse loads `time_wdata` into the time at the next clock edge, and it wins over a tick in the same cycle. The layout of the time bus (used for load, alarm and `time_q`) is year [35:29], month [28:25], day of week [24:22], day of month [21:17], hour [16:12], minute [11:6], second [5:0].
- R2: Each cycle with `sec_tick` high (and no load) adds one to the second at the next edge. With neither tick nor load, the time holds.
- R3: Second 59 wraps to 0 and adds one minute. Minute 59 wraps to 0 and adds one hour. Hour 23 wraps to 0 and adds one day.
- R4: Months run from 1 to 12. The last day of a month moves to day 1 of the next month. December 31 moves to January 1 of the next year, and year 127 wraps to 0. April, June, September and November have 30 days; the other months apart from February have 31.
- R5: February has 29 days when the year offset is a multiple of 4, except offset 100, where it has 28.
- R6: Day of week counts 0 to 6, wrapping to 0. It steps only when the day of month steps.
- R7: The alarm is compared once per tick, against the time after that tick's update. When `irq_en_q` bit 0 is set and every unmasked field matches, status bit 0 is set two edges after the tick cycle. Mask bit i excludes a field: 0 second, 1 minute, 2 hour, 3 day of month, 4 day of week, 5 month, 6 year.
- R8: When `irq_en_q` bit 2 (one-shot) and bit 0 are both set and the alarm fires, bit 0 clears in the same edge that sets the status. Later matches then set no status. Without one-shot, bit 0 stays set.
- R9: When `irq_en_q` bit 1 is set, every tick sets status bit 1 two edges after the tick cycle.
- R10: Status bits hold until cleared by `sta_clr_wr` with a 1 in the matching bit of `sta_clr_mask`. A set in the same edge wins over the clear.
- R11: `irq_n` is low exactly while some status bit is set together with its enable bit. Clearing the enable raises `irq_n` while the status stays set.
- R12: After reset the time is year 0, month 1, day 1, weekday 0, 00:00:00. The alarm, the mask, the enables and the status are all 0, and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-second strobe, one cycle wide |
| time_wr | input | 1 | Load strobe for the time |
| time_wdata | input | 36 | Time value to load |
| alarm_wr | input | 1 | Load strobe for the alarm |
| alarm_wdata | input | 36 | Alarm value to load |
| mask_wr | input | 1 | Load strobe for the alarm mask |
| mask_wdata | input | 7 | Alarm mask, one bit per field |
| en_wr | input | 1 | Load strobe for the interrupt enables |
| en_wdata | input | 3 | Enables: bit 0 alarm, bit 1 tick, bit 2 one-shot |
| sta_clr_wr | input | 1 | Status clear strobe |
| sta_clr_mask | input | 2 | Status bits to clear (bit 0 alarm, bit 1 tick) |
| time_q | output | 36 | Current time |
| irq_en_q | output | 3 | Current interrupt enables |
| irq_sta_q | output | 2 | Current status bits |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
A wrong carry or month-length decision appears on `time_q` one edge after the tick that reaches the boundary. The vector table therefore loads a time just before each boundary, applies one tick, and checks the result.

A wrong comparator or enable state appears on `irq_sta_q` and `irq_n` two edges after the tick. The directed tests sample at exactly that point. A one-shot fault appears on `irq_en_q` at that same edge, and again as an unwanted status after the next matching tick.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DOM_W   = 5;
    localparam int DOW_W   = 3;
    localparam int MON_W   = 4;
    localparam int YEAR_W  = 7;
    localparam int NUM_FIELDS = 7;
    localparam int FIELD_W = YEAR_W;
    localparam int TIME_W  = SEC_W + MIN_W + HOUR_W + DOM_W + DOW_W + MON_W + YEAR_W;
    localparam int EN_W    = 3;
    localparam int STA_W   = 2;

    localparam logic [SEC_W-1:0]  SEC_LAST   = SEC_W'(59);
    localparam logic [MIN_W-1:0]  MIN_LAST   = MIN_W'(59);
    localparam logic [HOUR_W-1:0] HOUR_LAST  = HOUR_W'(23);
    localparam logic [DOW_W-1:0]  DOW_LAST   = DOW_W'(6);
    localparam logic [MON_W-1:0]  MON_LAST   = MON_W'(12);
    localparam logic [YEAR_W-1:0] YEAR_NOLEAP = YEAR_W'(100);

    // Field order matches the external time bus (MSB first).
    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DOW_W-1:0]  dow;
        logic [DOM_W-1:0]  dom;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_time_t;

    // Mask bit index of each field; the day-of-week position is fixed at 4.
    typedef enum int {
        FLD_SEC  = 0,
        FLD_MIN  = 1,
        FLD_HOUR = 2,
        FLD_DOM  = 3,
        FLD_DOW  = 4,
        FLD_MON  = 5,
        FLD_YEAR = 6
    } field_e;

    // Bit 0 alarm enable, bit 1 tick enable, bit 2 one-shot select.
    typedef struct packed {
        logic oneshot;
        logic tick_en;
        logic alarm_en;
    } irq_en_t;

    // Bit 0 alarm seen, bit 1 tick seen.
    typedef struct packed {
        logic tick;
        logic alarm;
    } irq_sta_t;

    localparam cal_time_t TIME_AT_RESET = '{
        year:  '0,
        month: MON_W'(1),
        dow:   '0,
        dom:   DOM_W'(1),
        hour:  '0,
        min:   '0,
        sec:   '0
    };

    function automatic logic is_leap(input logic [YEAR_W-1:0] yr);
        return (yr[1:0] == 2'b00) && (yr != YEAR_NOLEAP);
    endfunction

    function automatic logic [DOM_W-1:0] days_in_month(input logic [MON_W-1:0] mon,
                                                       input logic [YEAR_W-1:0] yr);
        logic [DOM_W-1:0] d;
        case (mon)
            MON_W'(2):                         d = is_leap(yr) ? DOM_W'(29) : DOM_W'(28);
            MON_W'(4), MON_W'(6),
            MON_W'(9), MON_W'(11):             d = DOM_W'(30);
            default:                           d = DOM_W'(31);
        endcase
        return d;
    endfunction

    function automatic logic [FIELD_W-1:0] field_val(input cal_time_t t, input int idx);
        logic [FIELD_W-1:0] v;
        case (idx)
            FLD_SEC:  v = FIELD_W'(t.sec);
            FLD_MIN:  v = FIELD_W'(t.min);
            FLD_HOUR: v = FIELD_W'(t.hour);
            FLD_DOM:  v = FIELD_W'(t.dom);
            FLD_DOW:  v = FIELD_W'(t.dow);
            FLD_MON:  v = FIELD_W'(t.month);
            default:  v = t.year;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t cur
);

    cal_time_t        nxt;
    logic [DOM_W-1:0] month_len;
    logic             sec_wrap, min_wrap, hour_wrap, dom_wrap, mon_wrap;

    always_comb begin
        month_len = days_in_month(cur.month, cur.year);
        sec_wrap  = cur.sec   >= SEC_LAST;
        min_wrap  = cur.min   >= MIN_LAST;
        hour_wrap = cur.hour  >= HOUR_LAST;
        dom_wrap  = cur.dom   >= month_len;
        mon_wrap  = cur.month >= MON_LAST;
    end

    always_comb begin
        nxt = cur;
        if (load) begin
            nxt = load_val;
        end else if (tick) begin
            if (!sec_wrap) begin
                nxt.sec = cur.sec + 1'b1;
            end else begin
                nxt.sec = '0;
                if (!min_wrap) begin
                    nxt.min = cur.min + 1'b1;
                end else begin
                    nxt.min = '0;
                    if (!hour_wrap) begin
                        nxt.hour = cur.hour + 1'b1;
                    end else begin
                        nxt.hour = '0;
                        nxt.dow  = (cur.dow >= DOW_LAST) ? '0 : cur.dow + 1'b1;
                        if (!dom_wrap) begin
                            nxt.dom = cur.dom + 1'b1;
                        end else begin
                            nxt.dom = DOM_W'(1);
                            if (!mon_wrap) begin
                                nxt.month = cur.month + 1'b1;
                            end else begin
                                nxt.month = MON_W'(1);
                                nxt.year  = cur.year + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= TIME_AT_RESET;
        else     cur <= nxt;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(load_val)));                                   // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cur));                                   // R2

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cur.sec < SEC_LAST) |=> (cur.sec == $past(cur.sec) + 1'b1)); // R2

    AST_DOW_ONLY_ON_DAY: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cur.hour < HOUR_LAST) |=> $stable(cur.dow));        // R6

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_pkg::*;
(
    input  cal_time_t              cur,
    input  cal_time_t              alarm,
    input  logic [NUM_FIELDS-1:0]  mask,
    output logic                   match
);

    logic [NUM_FIELDS-1:0] field_ok;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign field_ok[i] = mask[i] || (field_val(cur, i) == field_val(alarm, i));
    end

    assign match = &field_ok;

endmodule

// File: rtl/cal_irq_ctrl.sv
module cal_irq_ctrl
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_evt,
    input  logic             alarm_match,
    input  logic             en_wr,
    input  logic [EN_W-1:0]  en_wdata,
    input  logic             clr_wr,
    input  logic [STA_W-1:0] clr_mask,
    output irq_en_t          en_q,
    output irq_sta_t         sta_q,
    output logic             irq_n
);

    irq_en_t  en_nxt;
    irq_sta_t sta_nxt, clr_sel;
    logic     alarm_fire;

    assign alarm_fire = tick_evt && alarm_match && en_q.alarm_en;
    assign clr_sel    = clr_wr ? irq_sta_t'(clr_mask) : '0;

    always_comb begin
        en_nxt = en_q;
        if (en_wr)
            en_nxt = irq_en_t'(en_wdata);
        else if (alarm_fire && en_q.oneshot)
            en_nxt.alarm_en = 1'b0;
    end

    always_comb begin
        sta_nxt.alarm = alarm_fire || (sta_q.alarm && !clr_sel.alarm);
        sta_nxt.tick  = (tick_evt && en_q.tick_en) || (sta_q.tick && !clr_sel.tick);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sta_q <= '0;
        end else begin
            en_q  <= en_nxt;
            sta_q <= sta_nxt;
        end
    end

    assign irq_n = !((sta_q.alarm && en_q.alarm_en) || (sta_q.tick && en_q.tick_en));

    AST_ONESHOT_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (alarm_fire && en_q.oneshot && !en_wr) |=> !en_q.alarm_en);           // R8

    AST_ALARM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(sta_q.alarm) |-> $past(en_q.alarm_en));                         // R7

    AST_STA_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sta_q.tick && !(clr_wr && clr_mask[1])) |=> sta_q.tick);             // R10

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (sta_q != '0));                                            // R11

endmodule

// File: rtl/cal_alarm_rtc.sv
module cal_alarm_rtc
    import cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sec_tick,
    input  logic                  time_wr,
    input  logic [TIME_W-1:0]     time_wdata,
    input  logic                  alarm_wr,
    input  logic [TIME_W-1:0]     alarm_wdata,
    input  logic                  mask_wr,
    input  logic [NUM_FIELDS-1:0] mask_wdata,
    input  logic                  en_wr,
    input  logic [EN_W-1:0]       en_wdata,
    input  logic                  sta_clr_wr,
    input  logic [STA_W-1:0]      sta_clr_mask,
    output logic [TIME_W-1:0]     time_q,
    output logic [EN_W-1:0]       irq_en_q,
    output logic [STA_W-1:0]      irq_sta_q,
    output logic                  irq_n
);

    cal_time_t             cur_time;
    cal_time_t             alarm_q;
    logic [NUM_FIELDS-1:0] mask_q;
    logic                  tick_d;
    logic                  match;
    irq_en_t               en_s;
    irq_sta_t              sta_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
            mask_q  <= '0;
            tick_d  <= 1'b0;
        end else begin
            if (alarm_wr) alarm_q <= cal_time_t'(alarm_wdata);
            if (mask_wr)  mask_q  <= mask_wdata;
            tick_d <= sec_tick && !time_wr;
        end
    end

    cal_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .load     (time_wr),
        .load_val (cal_time_t'(time_wdata)),
        .cur      (cur_time)
    );

    cal_alarm_cmp u_cmp (
        .cur   (cur_time),
        .alarm (alarm_q),
        .mask  (mask_q),
        .match (match)
    );

    cal_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .tick_evt    (tick_d),
        .alarm_match (match),
        .en_wr       (en_wr),
        .en_wdata    (en_wdata),
        .clr_wr      (sta_clr_wr),
        .clr_mask    (sta_clr_mask),
        .en_q        (en_s),
        .sta_q       (sta_s),
        .irq_n       (irq_n)
    );

    assign time_q    = cur_time;
    assign irq_en_q  = en_s;
    assign irq_sta_q = sta_s;

    AST_TICK_STATUS: assert property (@(posedge clk) disable iff (rst)
        (tick_d && en_s.tick_en) |=> irq_sta_q[1]);                          // R9

endmodule

// File: tb/sim_cal_alarm_rtc.sv
module sim_cal_alarm_rtc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic        time_wr = 1'b0;
    logic [35:0] time_wdata = '0;
    logic        alarm_wr = 1'b0;
    logic [35:0] alarm_wdata = '0;
    logic        mask_wr = 1'b0;
    logic [6:0]  mask_wdata = '0;
    logic        en_wr = 1'b0;
    logic [2:0]  en_wdata = '0;
    logic        sta_clr_wr = 1'b0;
    logic [1:0]  sta_clr_mask = '0;
    logic [35:0] time_q;
    logic [2:0]  irq_en_q;
    logic [1:0]  irq_sta_q;
    logic        irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cal_alarm_rtc u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .time_wr(time_wr), .time_wdata(time_wdata),
        .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .sta_clr_wr(sta_clr_wr), .sta_clr_mask(sta_clr_mask),
        .time_q(time_q), .irq_en_q(irq_en_q), .irq_sta_q(irq_sta_q), .irq_n(irq_n)
    );

    function automatic logic [35:0] pk(input int y, input int mo, input int dw,
                                       input int d, input int h, input int mi, input int s);
        return {y[6:0], mo[3:0], dw[2:0], d[4:0], h[4:0], mi[5:0], s[5:0]};
    endfunction

    // {requirement number, start time, expected time after one tick}
    localparam int NV = 15;
    localparam logic [75:0] VEC [NV] = '{
        {4'd2, pk(5,3,2,10,10,20,30),  pk(5,3,2,10,10,20,31)},   // R2
        {4'd3, pk(5,3,2,10,10,20,59),  pk(5,3,2,10,10,21,0)},    // R3
        {4'd3, pk(5,3,2,10,10,59,59),  pk(5,3,2,10,11,0,0)},     // R3
        {4'd3, pk(5,3,2,10,23,59,59),  pk(5,3,3,11,0,0,0)},      // R3
        {4'd6, pk(5,3,6,10,23,59,59),  pk(5,3,0,11,0,0,0)},      // R6
        {4'd4, pk(5,4,1,30,23,59,59),  pk(5,5,2,1,0,0,0)},       // R4
        {4'd4, pk(5,1,1,31,23,59,59),  pk(5,2,2,1,0,0,0)},       // R4
        {4'd4, pk(5,5,1,30,23,59,59),  pk(5,5,2,31,0,0,0)},      // R4
        {4'd5, pk(4,2,3,28,23,59,59),  pk(4,2,4,29,0,0,0)},      // R5
        {4'd5, pk(4,2,3,29,23,59,59),  pk(4,3,4,1,0,0,0)},       // R5
        {4'd5, pk(5,2,3,28,23,59,59),  pk(5,3,4,1,0,0,0)},       // R5
        {4'd5, pk(100,2,3,28,23,59,59),pk(100,3,4,1,0,0,0)},     // R5
        {4'd5, pk(0,2,3,28,23,59,59),  pk(0,2,4,29,0,0,0)},      // R5
        {4'd4, pk(7,12,5,31,23,59,59), pk(8,1,6,1,0,0,0)},       // R4
        {4'd4, pk(127,12,5,31,23,59,59),pk(0,1,6,1,0,0,0)}       // R4
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_time(input logic [35:0] v);
        @(negedge clk) begin time_wr = 1'b1; time_wdata = v; end
        @(negedge clk) time_wr = 1'b0;
    endtask

    task automatic set_en(input logic [2:0] v);
        @(negedge clk) begin en_wr = 1'b1; en_wdata = v; end
        @(negedge clk) en_wr = 1'b0;
    endtask

    task automatic set_alarm(input logic [35:0] v, input logic [6:0] m);
        @(negedge clk) begin
            alarm_wr = 1'b1; alarm_wdata = v; mask_wr = 1'b1; mask_wdata = m;
        end
        @(negedge clk) begin alarm_wr = 1'b0; mask_wr = 1'b0; end
    endtask

    task automatic clear_sta(input logic [1:0] m);
        @(negedge clk) begin sta_clr_wr = 1'b1; sta_clr_mask = m; end
        @(negedge clk) sta_clr_wr = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check("R12 time", time_q, pk(0,1,0,1,0,0,0));
        check("R12 en", irq_en_q, 3'b000);
        check("R12 sta", irq_sta_q, 2'b00);
        check("R12 irq_n", irq_n, 1'b1);

        // Calendar vectors
        for (int i = 0; i < NV; i++) begin
            load_time(VEC[i][71:36]);
            do_tick();
            check($sformatf("R%0d vector %0d", VEC[i][75:72], i), time_q, VEC[i][35:0]);
        end

        // R1: load beats a tick in the same cycle
        @(negedge clk) begin
            time_wr = 1'b1; time_wdata = pk(9,6,1,15,12,30,40); sec_tick = 1'b1;
        end
        @(negedge clk) begin time_wr = 1'b0; sec_tick = 1'b0; end
        check("R1 load priority", time_q, pk(9,6,1,15,12,30,40));

        // R2: no tick, time holds
        repeat (5) @(negedge clk);
        check("R2 hold", time_q, pk(9,6,1,15,12,30,40));

        // R7: masked day-of-week match raises alarm status and irq
        set_en(3'b001);
        set_alarm(pk(5,3,5,10,10,0,1), 7'b0010000);
        load_time(pk(5,3,2,10,10,0,0));
        do_tick();
        check("R7 masked match sta", irq_sta_q, 2'b01);
        check("R11 irq low on alarm", irq_n, 1'b0);
        check("R8 no oneshot keeps enable", irq_en_q, 3'b001);

        // R10: write-one clear
        clear_sta(2'b01);
        check("R10 clear", irq_sta_q, 2'b00);
        check("R11 irq high after clear", irq_n, 1'b1);

        // R7: day of week unmasked and differing -> no match
        set_alarm(pk(5,3,5,10,10,0,1), 7'b0000000);
        load_time(pk(5,3,2,10,10,0,0));
        do_tick();
        check("R7 unmasked mismatch", irq_sta_q, 2'b00);

        // R8: one-shot clears enable when firing
        set_en(3'b101);
        set_alarm(pk(5,3,5,10,10,0,1), 7'b0010000);
        load_time(pk(5,3,2,10,10,0,0));
        do_tick();
        check("R8 oneshot sta", irq_sta_q, 2'b01);
        check("R8 oneshot disarm", irq_en_q, 3'b100);
        clear_sta(2'b01);
        load_time(pk(5,3,2,10,10,0,0));
        do_tick();
        check("R8 no refire", irq_sta_q, 2'b00);

        // R9 / R11: tick status and irq gating
        set_en(3'b010);
        do_tick();
        check("R9 tick sta", irq_sta_q, 2'b10);
        check("R11 irq low on tick", irq_n, 1'b0);
        set_en(3'b000);
        check("R11 irq high when disabled", irq_n, 1'b1);
        check("R10 sta held", irq_sta_q, 2'b10);
        clear_sta(2'b10);
        check("R10 tick clear", irq_sta_q, 2'b00);

        // R10: set wins over clear in the same edge
        set_en(3'b010);
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) begin sec_tick = 1'b0; sta_clr_wr = 1'b1; sta_clr_mask = 2'b10; end
        @(negedge clk) sta_clr_wr = 1'b0;
        check("R10 set beats clear", irq_sta_q, 2'b10);

        done = 1;
        summary();
        $finish;
    end

endmodule